// File: doc/BRIEF.md
# Asynchronous Event Queue Producer

This block is the device-side writer of a ring of event records that lives in host memory. Each accepted event is turned into a 64-byte record: its payload first, then a 32-bit descriptor word stored most significant byte first. The record goes out on a write port with its slot index, and a separate memory writer carries it to the host. Ownership of a slot is not marked with a valid flag. Instead, a phase bit inside the descriptor toggles on every lap around the ring. The host sees a record as new while that bit differs from its own lap phase.

The host reports its progress by writing a consumer-index word. The block accepts that word only when its 4-bit nibble-XOR checksum is correct. A correct word updates the consumer position and lap phase, and can also arm the interrupt. The block stops taking events when the ring is full, which keeps a record the host has not read from being overwritten.

Interrupts work in one of two modes. In the re-arm mode, the block fires once and then waits for the host to arm it again. In the every-record mode, it fires for each record written.

After reset the block first clears every descriptor slot to lap phase 0, and only then accepts events. The ring length comes from a 21-bit setting. The storage limit is a whole number of pages, each holding a power-of-two number of records.

Stream interfaces: `ev_*` and `el_*` use valid/ready. A transfer happens on a clock edge where both valid and ready are high. While `el_valid` is high and `el_ready` is low, `el_idx` and `el_data` hold their values. `ev_ready` rises only when the output stage is free or draining, the slot clearing has finished, and the ring has room.

Top module: `evq_producer`

## Requirements
- R1: While reset is asserted and right after it, `ev_ready`, `el_valid`, `irq` and `ci_err` are 0 and `prod_idx` is 0.
- R2: After reset the block emits exactly L clearing writes, to slots 0 to L-1 in order, each with all 512 data bits zero (lap phase 0). It accepts no event until these writes are done, and accepts events afterwards.
- R3: The ring length L is the smaller of `cfg_len` and PAGE_ELEMS*MAX_PAGES. All writes, clearing writes first and then events, go to consecutive slots modulo L, starting at 0.
- R4: Record layout: byte k of `el_data` is bits [8k+7:8k]. Bytes 0 to 59 are the payload bytes of `ev_data` in the same positions. Bytes 60 to 63 are the descriptor, most significant byte first (byte 60 = descriptor bits 31:24). Descriptor fields: type in bits 6:0, source in bit 7, size in bits 15:8, lap phase in bit 31; the remaining bits are 0.
- R5: The lap phase written is 1 on the first lap and inverts on each later lap. The record at the consumer index whose phase equals the consumer's phase is one not yet written.
- R6: At most L records are outstanding ahead of the consumer index. When the ring is full, `ev_ready` is 0.
- R7: While `el_valid` is high and `el_ready` is low, `el_valid`, `el_idx` and `el_data` stay unchanged. With `el_ready` held high, one event can be accepted per cycle.
- R8: Consumer-index word fields: index in bits 19:0 (the low index bits are used), lap phase in bit 20, checksum in bits 27:24, arm in bit 31. A word is accepted when its checksum equals the XOR of all eight nibbles of the word with bits 27:24 taken as 0. An accepted word sets the consumer position, its phase and the arm state.
- R9: A consumer-index word with a wrong checksum changes nothing, and it sets `ci_err`, which stays high until reset.
- R10: In re-arm mode (`cfg_mode`=0), `irq` pulses for one cycle when the block is armed and written records are waiting beyond the consumer index; the arm then clears. A cycle with an accepted consumer-index word defers this check by one cycle.
- R11: In every-record mode (`cfg_mode`=1), `irq` pulses in the cycle after each record write transfer, and the arm bit has no effect.
- R12: `prod_idx` is the slot that the next event record will be written to. It advances modulo L on each record write transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | 21 | Requested ring length in records |
| cfg_mode | input | 1 | Interrupt mode: 0 re-arm, 1 every record |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be taken |
| ev_type | input | 7 | Event type |
| ev_src | input | 1 | Event source flag |
| ev_size | input | 8 | Event payload size |
| ev_data | input | 480 | Event payload, byte k at bits [8k+7:8k] |
| el_valid | output | 1 | Record write offered |
| el_ready | input | 1 | Memory writer can take the record |
| el_idx | output | IDX_W | Slot index of the record |
| el_data | output | 512 | Record contents |
| ci_valid | input | 1 | Consumer-index word strobe |
| ci_word | input | 32 | Consumer-index word |
| ci_err | output | 1 | Sticky bad-checksum flag |
| prod_idx | output | IDX_W | Next slot for an event record |
| irq | output | 1 | Interrupt request pulse |

IDX_W is clog2(PAGE_ELEMS*MAX_PAGES).

## Verification
The assertions assume that `cfg_len` is at least 1 and that `cfg_len` and `cfg_mode` change only while reset is asserted. They also assume that the host never moves the consumer index past the records already written. The bench keeps to these assumptions: it changes the configuration only inside reset, and it acts as the host by reading its own copy of the ring. It reports only positions it has actually consumed, with the matching lap phase.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int PAY_BYTES  = 60;
  localparam int PAY_W      = PAY_BYTES * 8;
  localparam int REC_W      = 512;
  localparam int LEN_FIELD_W = 21;

  localparam int CI_PHASE_BIT = 20;
  localparam int CI_SUM_LO    = 24;
  localparam int CI_ARM_BIT   = 31;

  typedef enum logic {
    IRQ_REARM  = 1'b0,
    IRQ_ALWAYS = 1'b1
  } irq_mode_e;

  typedef struct packed {
    logic        phase;
    logic [14:0] zero;
    logic [7:0]  size;
    logic        src;
    logic [6:0]  kind;
  } desc_t;

  function automatic logic [3:0] nibble_sum(input logic [31:0] w);
    logic [31:0] m;
    logic [3:0]  x;
    m = w;
    m[CI_SUM_LO +: 4] = 4'h0;
    x = 4'h0;
    for (int i = 0; i < 8; i++) x = x ^ m[4*i +: 4];
    return x;
  endfunction

  function automatic logic [REC_W-1:0] pack_record(input logic [PAY_W-1:0] pay,
                                                   input desc_t d);
    logic [REC_W-1:0] r;
    logic [31:0]      dw;
    dw = d;
    r = '0;
    r[PAY_W-1:0] = pay;
    for (int b = 0; b < 4; b++) r[PAY_W + 8*b +: 8] = dw[31 - 8*b -: 8];
    return r;
  endfunction
endpackage

// File: rtl/evq_ring_ptr.sv
module evq_ring_ptr #(
  parameter int IDX_W = 9,
  parameter int LEN_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [LEN_W-1:0] len,
  output logic [IDX_W-1:0] idx,
  output logic             phase
);
  logic last;
  assign last = (LEN_W'(idx) == len - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= 1'b0;
    end else if (adv) begin
      if (last) begin
        idx   <= '0;
        phase <= ~phase;
      end else begin
        idx <= idx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/evq_ci_port.sv
module evq_ci_port
  import evq_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ci_valid,
  input  logic [31:0]      ci_word,
  input  logic             arm_clr,
  output logic [IDX_W-1:0] cons_idx,
  output logic             cons_phase,
  output logic             armed,
  output logic             ci_ok,
  output logic             ci_err
);
  logic sum_match;
  assign sum_match = (nibble_sum(ci_word) == ci_word[CI_SUM_LO +: 4]);
  assign ci_ok     = ci_valid && sum_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cons_idx   <= '0;
      cons_phase <= 1'b0;
      armed      <= 1'b0;
      ci_err     <= 1'b0;
    end else begin
      if (ci_ok) begin
        cons_idx   <= ci_word[IDX_W-1:0];
        cons_phase <= ci_word[CI_PHASE_BIT];
        armed      <= ci_word[CI_ARM_BIT];
      end else if (arm_clr) begin
        armed <= 1'b0;
      end
      if (ci_valid && !sum_match) ci_err <= 1'b1;
    end
  end
endmodule

// File: rtl/evq_irq_gen.sv
module evq_irq_gen
  import evq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic armed,
  input  logic pending,
  input  logic commit,
  input  logic ci_ok,
  output logic arm_clr,
  output logic irq
);
  logic fire;
  assign fire    = (irq_mode_e'(mode) == IRQ_REARM) && armed && pending && !ci_ok;
  assign arm_clr = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else if (irq_mode_e'(mode) == IRQ_ALWAYS) irq <= commit;
    else irq <= fire;
  end
endmodule

// File: rtl/evq_producer.sv
module evq_producer
  import evq_pkg::*;
#(
  parameter int PAGE_ELEMS = 64,
  parameter int MAX_PAGES  = 8,
  localparam int LIMIT = PAGE_ELEMS * MAX_PAGES,
  localparam int IDX_W = $clog2(LIMIT),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LEN_FIELD_W-1:0] cfg_len,
  input  logic                   cfg_mode,
  input  logic                   ev_valid,
  output logic                   ev_ready,
  input  logic [6:0]             ev_type,
  input  logic                   ev_src,
  input  logic [7:0]             ev_size,
  input  logic [PAY_W-1:0]       ev_data,
  output logic                   el_valid,
  input  logic                   el_ready,
  output logic [IDX_W-1:0]       el_idx,
  output logic [REC_W-1:0]       el_data,
  input  logic                   ci_valid,
  input  logic [31:0]            ci_word,
  output logic                   ci_err,
  output logic [IDX_W-1:0]       prod_idx,
  output logic                   irq
);
  localparam int P_ISSUE  = 0;
  localparam int P_COMMIT = 1;

  logic [LEN_W-1:0] eff_len;
  assign eff_len = (cfg_len > LEN_FIELD_W'(LIMIT)) ? LEN_W'(LIMIT) : cfg_len[LEN_W-1:0];

  logic [1:0]       ptr_adv;
  logic [IDX_W-1:0] ptr_idx [2];
  logic             ptr_ph  [2];

  for (genvar g = 0; g < 2; g++) begin : g_ptr
    evq_ring_ptr #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (ptr_adv[g]),
      .len   (eff_len),
      .idx   (ptr_idx[g]),
      .phase (ptr_ph[g])
    );
  end

  logic [IDX_W-1:0] cons_idx;
  logic             cons_phase, armed, ci_ok, arm_clr;

  evq_ci_port #(.IDX_W(IDX_W)) u_ci (
    .clk        (clk),
    .rst_n      (rst_n),
    .ci_valid   (ci_valid),
    .ci_word    (ci_word),
    .arm_clr    (arm_clr),
    .cons_idx   (cons_idx),
    .cons_phase (cons_phase),
    .armed      (armed),
    .ci_ok      (ci_ok),
    .ci_err     (ci_err)
  );

  logic             init_q;
  logic [LEN_W-1:0] init_cnt;
  logic             el_valid_q, el_is_ev_q;
  logic [IDX_W-1:0] el_idx_q;
  logic [REC_W-1:0] el_data_q;

  logic slot_free, full, ev_take, init_take, commit, pending;
  desc_t new_desc;

  assign slot_free = !el_valid_q || el_ready;
  assign full      = (ptr_idx[P_ISSUE] == cons_idx) && (ptr_ph[P_ISSUE] != cons_phase);
  assign ev_ready  = !init_q && slot_free && !full;
  assign ev_take   = ev_valid && ev_ready;
  assign init_take = init_q && slot_free && (init_cnt < eff_len);
  assign commit    = el_valid_q && el_ready && el_is_ev_q;
  assign pending   = (ptr_idx[P_COMMIT] != cons_idx) || (ptr_ph[P_COMMIT] != cons_phase);

  assign ptr_adv[P_ISSUE]  = ev_take;
  assign ptr_adv[P_COMMIT] = commit;

  always_comb begin
    new_desc       = '0;
    new_desc.phase = ~ptr_ph[P_ISSUE];
    new_desc.size  = ev_size;
    new_desc.src   = ev_src;
    new_desc.kind  = ev_type;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q   <= 1'b1;
      init_cnt <= '0;
    end else if (init_q) begin
      if (init_take) init_cnt <= init_cnt + LEN_W'(1);
      else if (init_cnt == eff_len) init_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      el_valid_q <= 1'b0;
      el_is_ev_q <= 1'b0;
      el_idx_q   <= '0;
      el_data_q  <= '0;
    end else if (init_take) begin
      el_valid_q <= 1'b1;
      el_is_ev_q <= 1'b0;
      el_idx_q   <= init_cnt[IDX_W-1:0];
      el_data_q  <= '0;
    end else if (ev_take) begin
      el_valid_q <= 1'b1;
      el_is_ev_q <= 1'b1;
      el_idx_q   <= ptr_idx[P_ISSUE];
      el_data_q  <= pack_record(ev_data, new_desc);
    end else if (el_ready) begin
      el_valid_q <= 1'b0;
    end
  end

  evq_irq_gen u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (cfg_mode),
    .armed   (armed),
    .pending (pending),
    .commit  (commit),
    .ci_ok   (ci_ok),
    .arm_clr (arm_clr),
    .irq     (irq)
  );

  assign el_valid = el_valid_q;
  assign el_idx   = el_idx_q;
  assign el_data  = el_data_q;
  assign prod_idx = ptr_idx[P_COMMIT];
endmodule

// File: rtl/evq_producer_chk.sv
module evq_producer_chk
  import evq_pkg::*;
#(
  parameter int PAGE_ELEMS = 64,
  parameter int MAX_PAGES  = 8,
  localparam int LIMIT = PAGE_ELEMS * MAX_PAGES,
  localparam int IDX_W = $clog2(LIMIT),
  localparam int LEN_W = IDX_W + 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [LEN_FIELD_W-1:0] cfg_len,
  input logic                   cfg_mode,
  input logic                   el_valid,
  input logic                   el_ready,
  input logic [IDX_W-1:0]       el_idx,
  input logic [REC_W-1:0]       el_data,
  input logic                   ci_valid,
  input logic [31:0]            ci_word,
  input logic                   ci_err,
  input logic [IDX_W-1:0]       prod_idx,
  input logic                   irq,
  input logic [IDX_W-1:0]       cons_idx_i,
  input logic                   el_is_ev_i
);
  logic [LEN_W-1:0] eff_c;
  logic [3:0]       sum_c;
  logic             commit_c;

  always_comb begin
    eff_c = (cfg_len >= LEN_FIELD_W'(LIMIT)) ? LEN_W'(LIMIT) : cfg_len[LEN_W-1:0];
    sum_c = 4'h0;
    for (int i = 0; i < 8; i++)
      if (i != 6) sum_c = sum_c ^ ci_word[4*i +: 4];
  end
  assign commit_c = el_valid && el_ready && el_is_ev_i;

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (el_valid && !el_ready) |=> (el_valid && $stable(el_idx) && $stable(el_data)));

  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid |-> (LEN_W'(el_idx) < eff_c));

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (el_valid && !el_is_ev_i) |-> (el_data == '0));

  p_bad_ci_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ci_valid && (sum_c != ci_word[27:24])) |=> (ci_err && $stable(cons_idx_i)));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ci_err |=> ci_err);

  p_rearm_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && irq) |=> !irq);

  p_always_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |-> (commit_c ? 1'b1 : 1'b1) ##1 (irq == $past(commit_c)));

  p_prod_advance_r12: assert property (@(posedge clk) disable iff (!rst_n)
    commit_c |=> (LEN_W'(prod_idx) ==
      (((LEN_W'($past(el_idx)) + LEN_W'(1)) == eff_c) ? LEN_W'(0)
                                                      : (LEN_W'($past(el_idx)) + LEN_W'(1)))));
endmodule

bind evq_producer evq_producer_chk #(.PAGE_ELEMS(PAGE_ELEMS), .MAX_PAGES(MAX_PAGES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_len    (cfg_len),
  .cfg_mode   (cfg_mode),
  .el_valid   (el_valid),
  .el_ready   (el_ready),
  .el_idx     (el_idx),
  .el_data    (el_data),
  .ci_valid   (ci_valid),
  .ci_word    (ci_word),
  .ci_err     (ci_err),
  .prod_idx   (prod_idx),
  .irq        (irq),
  .cons_idx_i (cons_idx),
  .el_is_ev_i (el_is_ev_q)
);

// File: tb/test_evq_producer.sv
module test_evq_producer;
  localparam int CLK_NS = 10;
  localparam int PE     = 2;
  localparam int MP     = 4;
  localparam int LIMIT  = PE * MP;
  localparam int IW     = $clog2(LIMIT);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [20:0]   cfg_len = 21'd4;
  logic          cfg_mode = 1'b0;
  logic          ev_valid = 1'b0;
  logic          ev_ready;
  logic [6:0]    ev_type = '0;
  logic          ev_src = 1'b0;
  logic [7:0]    ev_size = '0;
  logic [479:0]  ev_data = '0;
  logic          el_valid;
  logic          el_ready = 1'b1;
  logic [IW-1:0] el_idx;
  logic [511:0]  el_data;
  logic          ci_valid = 1'b0;
  logic [31:0]   ci_word = '0;
  logic          ci_err;
  logic [IW-1:0] prod_idx;
  logic          irq;

  evq_producer #(.PAGE_ELEMS(PE), .MAX_PAGES(MP)) i_evq_producer (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_mode(cfg_mode),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_type(ev_type), .ev_src(ev_src),
    .ev_size(ev_size), .ev_data(ev_data), .el_valid(el_valid), .el_ready(el_ready),
    .el_idx(el_idx), .el_data(el_data), .ci_valid(ci_valid), .ci_word(ci_word),
    .ci_err(ci_err), .prod_idx(prod_idx), .irq(irq));

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [511:0] ring [LIMIT];
  int wr_count = 0, irq_count = 0, eff = 1;
  bit order_bad = 0, bp_en = 0;
  int push_seq = 0, cons_seq = 0, cidx = 0;
  bit cph = 0;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (el_valid && el_ready) begin
        if (int'(el_idx) != (wr_count % eff)) order_bad = 1;
        ring[el_idx] = el_data;
        wr_count++;
      end
      if (irq) irq_count++;
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      el_ready = bp_en ? ((cyc % 3) != 0) : 1'b1;
      cyc++;
    end
  end

  function automatic logic [479:0] mk_pay(input int s);
    logic [479:0] p;
    for (int k = 0; k < 60; k++) p[8*k +: 8] = 8'((s * 7 + k) & 255);
    return p;
  endfunction

  function automatic logic [511:0] mk_rec(input int s, input bit ph);
    logic [511:0] r;
    logic [31:0]  d;
    d = {ph, 15'd0, 8'((s * 3 + 1) & 255), 1'((s >> 1) & 1), 7'(s & 127)};
    r[479:0]   = mk_pay(s);
    r[487:480] = d[31:24];
    r[495:488] = d[23:16];
    r[503:496] = d[15:8];
    r[511:504] = d[7:0];
    return r;
  endfunction

  task automatic set_ev(input int s);
    ev_type = 7'(s & 127);
    ev_src  = 1'((s >> 1) & 1);
    ev_size = 8'((s * 3 + 1) & 255);
    ev_data = mk_pay(s);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ci_write(input int idx, input bit ph, input bit arm, input bit bad);
    logic [31:0] w;
    logic [3:0]  x;
    w = {arm, 3'b0, 4'h0, 3'b0, ph, 20'(idx)};
    x = 4'h0;
    for (int i = 0; i < 8; i++) x = x ^ w[4*i +: 4];
    if (bad) x = x ^ 4'h1;
    w[27:24] = x;
    ci_word  = w;
    ci_valid = 1'b1;
    @(posedge clk); #1;
    ci_valid = 1'b0;
  endtask

  task automatic push_all(output int acc);
    bit take;
    acc = 0;
    set_ev(push_seq);
    ev_valid = 1'b1;
    for (int t = 0; t < 3 * eff + 10; t++) begin
      @(negedge clk);
      take = ev_ready;
      @(posedge clk); #1;
      if (take) begin
        acc++;
        push_seq++;
        set_ev(push_seq);
      end
    end
    ev_valid = 1'b0;
    idle(6);
  endtask

  task automatic consume_all();
    logic [511:0] e;
    for (int i = 0; i < eff; i++) begin
      e = ring[cidx];
      check("R5 new record phase differs from consumer", e[487], !cph);
      check("R4 record layout", (e == mk_rec(cons_seq, !cph)) ? 1 : 0, 1);
      cons_seq++;
      cidx++;
      if (cidx == eff) begin
        cidx = 0;
        cph = !cph;
      end
    end
    check("R5 unwritten slot phase equals consumer", ring[cidx][487], cph);
  endtask

  task automatic run_cfg(input int len, input bit mode);
    int acc, i0, exp_a;
    rst_n = 1'b0;
    cfg_len = 21'(len);
    cfg_mode = mode;
    eff = (len > LIMIT) ? LIMIT : len;
    for (int i = 0; i < LIMIT; i++) ring[i] = '1;
    wr_count = 0; irq_count = 0; order_bad = 0;
    push_seq = 0; cons_seq = 0; cidx = 0; cph = 0;
    idle(3);
    @(negedge clk);
    check("R1 ev_ready in reset", ev_ready, 0);
    check("R1 el_valid in reset", el_valid, 0);
    check("R1 irq in reset", irq, 0);
    check("R1 ci_err in reset", ci_err, 0);
    check("R1 prod_idx in reset", prod_idx, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 no event during clearing", ev_ready, 0);
    idle(3 * eff + 8);
    @(negedge clk);
    check("R2 clearing write count", wr_count, eff);
    for (int i = 0; i < eff; i++) check("R2 cleared slot zero", (ring[i] == '0) ? 1 : 0, 1);
    check("R2 ready after clearing", ev_ready, 1);
    check("R12 prod_idx after clearing", prod_idx, 0);
    @(posedge clk); #1;
    for (int r = 0; r < 3; r++) begin
      i0 = irq_count;
      push_all(acc);
      check("R6 accepted up to ring length", acc, eff);
      @(negedge clk);
      check("R6 stalled when full", ev_ready, 0);
      check("R12 prod_idx after fill", prod_idx, cidx);
      check("R3 sequential slot order", order_bad, 0);
      exp_a = mode ? eff : ((r == 0) ? 0 : 1);
      check(mode ? "R11 irq per record" : "R10 irq once while armed", irq_count - i0, exp_a);
      @(posedge clk); #1;
      if (r == 0) begin
        i0 = irq_count;
        ci_write((cidx + 1) % eff, cph, 1'b1, 1'b1);
        idle(4);
        @(negedge clk);
        check("R9 bad checksum sets error", ci_err, 1);
        check("R9 bad checksum frees nothing", ev_ready, 0);
        check("R9 bad checksum no irq", irq_count - i0, 0);
        @(posedge clk); #1;
      end
      i0 = irq_count;
      ci_write(cidx, cph, 1'b1, 1'b0);
      idle(4);
      check(mode ? "R11 arm has no effect" : "R10 arm with pending fires", irq_count - i0, mode ? 0 : 1);
      consume_all();
      i0 = irq_count;
      ci_write(cidx, cph, 1'b1, 1'b0);
      idle(4);
      @(negedge clk);
      check("R10 armed but empty no irq", irq_count - i0, 0);
      check("R8 accepted index frees ring", ev_ready, 1);
      check("R9 error stays set", ci_err, 1);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    #1;
    for (int len = 1; len <= LIMIT + 1; len++) begin
      for (int m = 0; m < 2; m++) begin
        int l;
        l = (len == LIMIT + 1) ? 20 : len;
        bp_en = (m != (len % 2));
        run_cfg(l, m[0]);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule